// File: doc/BRIEF.md
# Expansion ROM Access Sequencer

This block runs single read and write cycles against a slow external parallel memory, typically Flash or EPROM, over an address bus, an input data bus and an output data bus. A host asks for a transfer by presenting an address, write data, a direction bit and a width bit, then pulsing a start strobe. The sequencer drives chip select and write enable, both active low, for a length of time set by a programmable timing field. When the cycle is over it pulses done for one clock and, on a read, presents the captured data in that same cycle. The data path is 16 bits wide, or 8 bits wide with the upper byte forced to zero, and the width is chosen for each request.

The timing field is 4 bits wide. A transfer lasts the field value plus one clocks. The field can be read at any time. It accepts new values only while the stop input is high, and it refuses zero. A hardware reset loads 9. The soft reset input aborts any transfer in progress but leaves the timing field as it is. A transfer takes its timing from the field at the moment the request is accepted.

Top module: `xrom_seq`

## Requirements
- R1: After the hardware reset (rst_n low), cfg_rd_data reads 4'b1001, mem_cs_n and mem_we_n are 1, and mem_dout_oe, busy and req_done are 0.
- R2: A pulse on cfg_wr_en changes cfg_rd_data to cfg_wr_data on the next clock only when stop_i is 1. With stop_i at 0 the write is ignored.
- R3: A write of 0 to the timing field is ignored and the previous value stays.
- R4: On a read (req_write=0), mem_cs_n is low and mem_addr holds req_addr for exactly field+1 cycles, starting in the cycle after the start is accepted. mem_din is captured on the last of those clock edges, and mem_we_n stays 1.
- R5: On a write (req_write=1), mem_cs_n is low for field+2 cycles. mem_we_n is low, and mem_dout is driven with mem_dout_oe=1, for field+1 cycles. That window begins one cycle after mem_cs_n falls and ends on the same edge as mem_cs_n rising.
- R6: req_done is a single-cycle pulse in the cycle after mem_cs_n rises. On a read, req_rdata holds the captured data in that cycle. busy is 1 from the cycle after acceptance through the last cycle with mem_cs_n low, and 0 during done.
- R7: A req_start seen while busy is 1 is ignored and produces no extra access.
- R8: With req_wide=0, req_rdata[15:8] and mem_dout[15:8] are zero, and only the low byte of the data is used. With req_wide=1 all 16 bits pass through.
- R9: soft_rst aborts an access. On the next cycle mem_cs_n and mem_we_n are 1 and busy is 0, no done pulse follows, and the timing field is unchanged.
- R10: An access uses the timing value present when its start was accepted. A later change to the field during that access does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous abort of the access sequencer |
| stop_i | input | 1 | Controller stopped; unlocks timing writes |
| cfg_wr_en | input | 1 | Timing field write strobe |
| cfg_wr_data | input | 4 | Timing field write value |
| cfg_rd_data | output | 4 | Current timing field |
| req_start | input | 1 | Start a transfer (honoured when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit transfer |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 16 | Write data |
| req_rdata | output | 16 | Read data, valid with req_done |
| req_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| mem_addr | output | ADDR_W | External address bus |
| mem_din | input | 16 | External data input |
| mem_dout | output | 16 | External data output |
| mem_dout_oe | output | 1 | Output data enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest situations to reach from the ports are the collisions: a second start arriving while a transfer runs, a soft reset landing in the middle of a write, and a timing update landing in the middle of an access. Each needs a stimulus that sits at a precise cycle inside the transfer. The bench gets there by driving these inputs at the negative edges that follow acceptance. It then counts the low cycles of chip select and write enable and compares them with the field value captured at acceptance.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

  localparam int TIM_W  = 4;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = TIM_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } seq_state_t;

  // Length in clocks of the timed part of an access.
  function automatic logic [CNT_W-1:0] access_cycles(input logic [TIM_W-1:0] field);
    return {1'b0, field} + CNT_W'(1);
  endfunction

  // Zero is not a legal timing value.
  function automatic logic timing_legal(input logic [TIM_W-1:0] value);
    return value != '0;
  endfunction

  // Narrow transfers keep only the low byte; the upper byte reads as zero.
  function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] data,
                                                   input logic wide);
    return wide ? data : {{(DATA_W-BYTE_W){1'b0}}, data[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/xrom_timing_reg.sv
module xrom_timing_reg
  import xrom_pkg::*;
#(
  parameter logic [TIM_W-1:0] TIM_INIT = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             wr_en,
  input  logic [TIM_W-1:0] wr_data,
  output logic [TIM_W-1:0] value,
  output logic             take_evt
);

  // Update only while stopped and only with a legal value.
  assign take_evt = wr_en && stop_i && timing_legal(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= TIM_INIT;
    end else if (take_evt) begin
      value <= wr_data;
    end
  end

endmodule

// File: rtl/xrom_lane_mux.sv
module xrom_lane_mux
  import xrom_pkg::*;
(
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              act_wide,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] wdata_fit,
  output logic [DATA_W-1:0] rdata_fit
);

  assign wdata_fit = fit_width(req_wdata, req_wide);
  assign rdata_fit = fit_width(bus_din, act_wide);

endmodule

// File: rtl/xrom_cycle_fsm.sv
module xrom_cycle_fsm
  import xrom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [TIM_W-1:0]  tim,
  input  logic              start,
  input  logic              write,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata_fit,
  input  logic [DATA_W-1:0] rdata_fit,
  output logic              act_wide,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              accept_evt,
  output logic              end_evt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  assign busy       = (state != ST_IDLE);
  assign accept_evt = (state == ST_IDLE) && start && !soft_rst;
  assign end_evt    = (state == ST_ACCESS) && (cnt == LAST) && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      wr_q        <= 1'b0;
      act_wide    <= 1'b0;
      done        <= 1'b0;
      rdata       <= '0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_oe <= 1'b0;
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
    end else if (soft_rst) begin
      state       <= ST_IDLE;
      done        <= 1'b0;
      mem_dout_oe <= 1'b0;
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mem_addr <= addr;
            mem_dout <= wdata_fit;
            wr_q     <= write;
            act_wide <= wide;
            mem_cs_n <= 1'b0;
            cnt      <= access_cycles(tim);
            state    <= write ? ST_SETUP : ST_ACCESS;
          end
        end
        ST_SETUP: begin
          mem_we_n    <= 1'b0;
          mem_dout_oe <= 1'b1;
          state       <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (cnt == LAST) begin
            mem_cs_n    <= 1'b1;
            mem_we_n    <= 1'b1;
            mem_dout_oe <= 1'b0;
            done        <= 1'b1;
            if (!wr_q) begin
              rdata <= rdata_fit;
            end
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - LAST;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xrom_seq.sv
module xrom_seq
  import xrom_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [TIM_W-1:0] TIM_INIT = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_i,
  input  logic              cfg_wr_en,
  input  logic [TIM_W-1:0]  cfg_wr_data,
  output logic [TIM_W-1:0]  cfg_rd_data,
  input  logic              req_start,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_done,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_din,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n
);

  logic              cfg_take;
  logic              accept_evt;
  logic              end_evt;
  logic              act_wide;
  logic [DATA_W-1:0] wdata_fit;
  logic [DATA_W-1:0] rdata_fit;

  xrom_timing_reg #(.TIM_INIT(TIM_INIT)) u_tim (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .value    (cfg_rd_data),
    .take_evt (cfg_take)
  );

  xrom_lane_mux u_lane (
    .req_wide  (req_wide),
    .req_wdata (req_wdata),
    .act_wide  (act_wide),
    .bus_din   (mem_din),
    .wdata_fit (wdata_fit),
    .rdata_fit (rdata_fit)
  );

  xrom_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .tim         (cfg_rd_data),
    .start       (req_start),
    .write       (req_write),
    .wide        (req_wide),
    .addr        (req_addr),
    .wdata_fit   (wdata_fit),
    .rdata_fit   (rdata_fit),
    .act_wide    (act_wide),
    .busy        (busy),
    .done        (req_done),
    .rdata       (req_rdata),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_oe (mem_dout_oe),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .accept_evt  (accept_evt),
    .end_evt     (end_evt)
  );

endmodule

// File: rtl/xrom_seq_chk.sv
module xrom_seq_chk
  import xrom_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             stop_i,
  input logic [TIM_W-1:0] cfg_wr_data,
  input logic [TIM_W-1:0] cfg_rd_data,
  input logic             cfg_take,
  input logic             req_write,
  input logic             req_done,
  input logic             busy,
  input logic             mem_dout_oe,
  input logic             mem_cs_n,
  input logic             mem_we_n,
  input logic             accept_evt,
  input logic             end_evt
);

  logic [CNT_W:0] lim;
  logic [CNT_W:0] run;
  logic           run_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim       <= '0;
      run       <= '0;
      run_valid <= 1'b0;
    end else if (soft_rst) begin
      run_valid <= 1'b0;
    end else if (accept_evt) begin
      lim       <= {1'b0, access_cycles(cfg_rd_data)} + (req_write ? (CNT_W+1)'(1) : '0);
      run       <= '0;
      run_valid <= 1'b1;
    end else if (!mem_cs_n) begin
      run <= run + (CNT_W+1)'(1);
    end
  end

  // R1
  timing_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data != '0);

  // R2
  timing_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rd_data) |-> $past(stop_i));

  // R3
  timing_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> (cfg_rd_data == $past(cfg_wr_data)) && (cfg_rd_data != '0));

  // R4
  cs_window_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(mem_cs_n) && run_valid) |-> (run == lim));

  // R5
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R5
  we_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  // R5
  oe_tracks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_oe == !mem_we_n);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R6
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (req_done && !busy));

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !busy);

  // R9
  soft_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mem_cs_n && mem_we_n && !busy && !req_done));

endmodule

bind xrom_seq xrom_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .stop_i      (stop_i),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .cfg_take    (cfg_take),
  .req_write   (req_write),
  .req_done    (req_done),
  .busy        (busy),
  .mem_dout_oe (mem_dout_oe),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .accept_evt  (accept_evt),
  .end_evt     (end_evt)
);

// File: tb/sim_xrom_seq.sv
`timescale 1ns/1ps
module sim_xrom_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        stop_i = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_data = '0;
  logic [3:0]  cfg_rd_data;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] req_rdata;
  logic        req_done;
  logic        busy;
  logic [15:0] mem_addr;
  logic [15:0] mem_din = '0;
  logic [15:0] mem_dout;
  logic        mem_dout_oe;
  logic        mem_cs_n;
  logic        mem_we_n;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xrom_seq u0 (.*);

  // {write, wide, timing, addr, data}
  localparam logic [37:0] VECS [8] = '{
    {1'b0, 1'b1, 4'd1,  16'h0010, 16'hA55A},
    {1'b0, 1'b0, 4'd9,  16'h0123, 16'hBEEF},
    {1'b1, 1'b1, 4'd1,  16'h0200, 16'h1234},
    {1'b1, 1'b0, 4'd4,  16'h0301, 16'hCAFE},
    {1'b0, 1'b1, 4'd15, 16'h7FF0, 16'h0F0F},
    {1'b1, 1'b1, 4'd15, 16'h8001, 16'hF00D},
    {1'b0, 1'b0, 4'd2,  16'hFFFF, 16'h00C3},
    {1'b1, 1'b0, 4'd7,  16'h4444, 16'h9966}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_tim(input logic [3:0] v, input logic stp);
    @(negedge clk);
    stop_i = stp; cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic run_access(input logic w, input logic wd, input logic [15:0] a,
                            input logic [15:0] d, output int cs_c, output int we_c,
                            output int bz_c, output logic a_ok, output logic [15:0] rd,
                            output logic [15:0] dq, output logic got);
    @(negedge clk);
    req_start = 1'b1; req_write = w; req_wide = wd; req_addr = a;
    req_wdata = d; mem_din = d;
    @(negedge clk);
    req_start = 1'b0;
    cs_c = 0; we_c = 0; bz_c = 0; a_ok = 1'b1; rd = '0; dq = '0; got = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (req_done) begin
        got = 1'b1; rd = req_rdata;
        break;
      end
      if (!mem_cs_n) begin
        cs_c++;
        if (mem_addr !== a) a_ok = 1'b0;
      end
      if (!mem_we_n) begin
        we_c++; dq = mem_dout;
      end
      if (busy) bz_c++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int cs_c, we_c, bz_c;
    logic a_ok, got;
    logic [15:0] rd, dq, expd;
    logic [3:0] tm;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 timing default", cfg_rd_data, 4'b1001);
    chk("R1 cs_n idle", mem_cs_n, 1);
    chk("R1 we_n idle", mem_we_n, 1);
    chk("R1 busy idle", busy, 0);
    chk("R1 done idle", req_done, 0);
    chk("R1 oe idle", mem_dout_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", cfg_rd_data, 4'b1001);

    // R2 locked write ignored, then read uses the default length
    set_tim(4'd3, 1'b0);
    chk("R2 locked write ignored", cfg_rd_data, 4'b1001);
    run_access(1'b0, 1'b1, 16'h0042, 16'h5A5A, cs_c, we_c, bz_c, a_ok, rd, dq, got);
    chk("R2 length with default timing", cs_c, 10);

    // R3 zero write ignored
    set_tim(4'd5, 1'b1);
    chk("R2 unlocked write", cfg_rd_data, 4'd5);
    set_tim(4'd0, 1'b1);
    chk("R3 zero write ignored", cfg_rd_data, 4'd5);

    // Vector table
    foreach (VECS[k]) begin
      logic w, wd;
      logic [15:0] a, d;
      {w, wd, tm, a, d} = VECS[k];
      set_tim(tm, 1'b1);
      chk("R2 table timing", cfg_rd_data, tm);
      run_access(w, wd, a, d, cs_c, we_c, bz_c, a_ok, rd, dq, got);
      expd = wd ? d : {8'h00, d[7:0]};
      chk("R6 done seen", got, 1);
      chk("R4 address held", a_ok, 1);
      if (!w) begin
        chk("R4 read cs length", cs_c, tm + 1);
        chk("R4 read no we", we_c, 0);
        chk("R8 R4 read data", rd, expd);
        chk("R6 busy window read", bz_c, tm + 1);
      end else begin
        chk("R5 write cs length", cs_c, tm + 2);
        chk("R5 write we length", we_c, tm + 1);
        chk("R8 R5 write data", dq, expd);
        chk("R6 busy window write", bz_c, tm + 2);
      end
      chk("R6 busy low at done", busy, 0);
      @(negedge clk);
      chk("R6 done single pulse", req_done, 0);
    end

    // R7 start while busy ignored
    set_tim(4'd3, 1'b1);
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 16'h1111;
    mem_din = 16'h2222;
    @(negedge clk);
    req_addr = 16'h9999;
    begin
      int cs_n_cnt, dn_cnt, bad_a;
      cs_n_cnt = 0; dn_cnt = 0; bad_a = 0;
      for (int i = 0; i < 14; i++) begin
        if (i == 1) req_start = 1'b0;
        if (!mem_cs_n) begin
          cs_n_cnt++;
          if (mem_addr !== 16'h1111) bad_a++;
        end
        if (req_done) dn_cnt++;
        @(negedge clk);
      end
      chk("R7 single access length", cs_n_cnt, 4);
      chk("R7 single done", dn_cnt, 1);
      chk("R7 first address kept", bad_a, 0);
      chk("R7 idle afterwards", busy, 0);
    end

    // R9 soft reset mid write
    set_tim(4'd6, 1'b1);
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b1; req_wide = 1'b1; req_addr = 16'h0ABC;
    req_wdata = 16'h7777;
    @(negedge clk);
    req_start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 write under way", mem_we_n, 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R9 cs released", mem_cs_n, 1);
    chk("R9 we released", mem_we_n, 1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 timing kept", cfg_rd_data, 4'd6);
    begin
      int dn_cnt;
      dn_cnt = 0;
      for (int i = 0; i < 10; i++) begin
        if (req_done) dn_cnt++;
        @(negedge clk);
      end
      chk("R9 no done after abort", dn_cnt, 0);
    end
    run_access(1'b0, 1'b0, 16'h0055, 16'h3C81, cs_c, we_c, bz_c, a_ok, rd, dq, got);
    chk("R9 R4 access after abort", cs_c, 7);
    chk("R9 R8 narrow data after abort", rd, 16'h0081);

    // R10 timing captured at start
    set_tim(4'd2, 1'b1);
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 16'h0F00;
    mem_din = 16'h1357;
    @(negedge clk);
    req_start = 1'b0;
    cfg_wr_en = 1'b1; cfg_wr_data = 4'd7;
    begin
      int cs_n_cnt;
      cs_n_cnt = 0;
      for (int i = 0; i < 12; i++) begin
        if (i == 1) cfg_wr_en = 1'b0;
        if (!mem_cs_n) cs_n_cnt++;
        @(negedge clk);
      end
      chk("R10 length from captured timing", cs_n_cnt, 3);
      chk("R10 field updated", cfg_rd_data, 4'd7);
    end

    // R1 hardware reset reloads default
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 hard reset reload", cfg_rd_data, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule